// File: doc/BRIEF.md
# UART Transmit Queue with Ninth Bit

This block sits between a software-visible transmit-data register and a serial transmitter core. Every software write lands on one address. The block stores the byte together with a ninth "address" bit, which a multiprocessor-addressing transmitter uses to mark address frames. The transmitter core sees the oldest stored entry through a valid/ready handshake. A ready pulse removes that entry.

The block drives three flags. A room flag means the next write will not overwrite queued data. A threshold flag means the queue is at least half empty. A sticky overflow flag records a write that was dropped. A masked interrupt combines the room and threshold flags under two separate enables. A flush input discards everything that is queued. When the queue is switched off, the block behaves as a single transmit holding register: the capacity drops to one entry and the same write address is used.

Top module: `txq_fifo`

## Requirements
- R1: After reset the queue is empty: `headValid`=0, `roomFlag`=1, `halfFlag`=1, `ovfFlag`=0.
- R2: `headData` and `headAddrBit` show the oldest accepted entry, so the 9-bit values leave in the order they were written.
- R3: With `fifoOn`=1 the queue holds up to DEPTH (16) entries. `headValid` is 1 exactly when at least one entry is stored.
- R4: An entry is removed only on a cycle where `headReady`=1 and `headValid`=1. `headReady` has no effect while the queue is empty.
- R5: `roomFlag` is 1 exactly when the number of stored entries is below the current capacity.
- R6: `halfFlag` is 1 exactly when the number of stored entries is at most half the capacity. That is 8 or fewer entries with `fifoOn`=1, and 0 entries with `fifoOn`=0.
- R7: A write while full is dropped and leaves the stored entries unchanged. It sets `ovfFlag`, which stays 1 until a flush.
- R8: `flush`=1 empties the queue and clears `ovfFlag` on the next edge. A write or pop in the same cycle is ignored.
- R9: With `fifoOn`=0 the capacity is one entry. `fifoOn` may change only while the queue is empty.
- R10: `irq` = (`halfIrqEn` AND `halfFlag`) OR (`roomIrqEn` AND `roomFlag`).
- R11: A write and a pop in the same cycle, when not full, both take effect and the entry count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Software write strobe to the transmit-data address |
| wrData | input | 8 | Byte to queue |
| wrAddrBit | input | 1 | Ninth (address) bit stored with the byte |
| fifoOn | input | 1 | 1: 16-entry queue, 0: single holding register |
| flush | input | 1 | Discard all entries and clear overflow |
| halfIrqEn | input | 1 | Enable interrupt from `halfFlag` |
| roomIrqEn | input | 1 | Enable interrupt from `roomFlag` |
| headReady | input | 1 | Transmitter core takes the head entry |
| headValid | output | 1 | Head entry present |
| headData | output | 8 | Head byte |
| headAddrBit | output | 1 | Head ninth bit |
| roomFlag | output | 1 | Not full |
| halfFlag | output | 1 | At least half empty |
| ovfFlag | output | 1 | Sticky: a write was dropped |
| irq | output | 1 | Masked interrupt |

## Verification
The bench fills the queue past sixteen entries with varied ninth bits. A design that wraps its pointer early or accepts the seventeenth write would corrupt the head order or miss the overflow flag. The threshold is checked at exactly 8 and 9 entries, where an off-by-one comparison would flip `halfFlag`. The bench also issues a write, a pop and a flush in the same cycle, expecting the flush to win, and a write and pop together while full, expecting the write to be dropped. It pops an empty queue, which must not move the pointers. In single-register mode a second write must set overflow instead of being queued.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;   // store the incoming entry at the tail
    logic pop;    // retire the head entry
    logic clear;  // reset both pointers
  } txqStrobe_t;
endpackage

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       fifoOn,
  input  logic       flush,
  input  logic       headReady,
  input  logic       halfIrqEn,
  input  logic       roomIrqEn,
  output txqStrobe_t stb,
  output logic       headValid,
  output logic       roomFlag,
  output logic       halfFlag,
  output logic       ovfFlag,
  output logic       irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CAP_ON  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_OFF = CNT_W'(1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cap;
  logic             full;
  logic             pushOk;
  logic             popOk;

  // capacity depends on the mode
  assign cap  = fifoOn ? CAP_ON : CAP_OFF;
  assign full = (count >= cap);

  assign pushOk = wrEn && !full && !flush;
  assign popOk  = headReady && (count != '0) && !flush;

  always_comb begin
    stb       = '0;
    stb.push  = pushOk;
    stb.pop   = popOk;
    stb.clear = flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      count <= '0;
    end else if (pushOk && !popOk) begin
      count <= count + 1'b1;
    end else if (popOk && !pushOk) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      ovfFlag <= 1'b0;
    end else if (wrEn && full) begin
      ovfFlag <= 1'b1;
    end
  end

  assign headValid = (count != '0);
  assign roomFlag  = !full;
  assign halfFlag  = (count <= (cap >> 1));
  assign irq       = (halfIrqEn && halfFlag) || (roomIrqEn && roomFlag);
endmodule

// File: rtl/txq_data.sv
module txq_data
  import txq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txqStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrAddrBit,
  output logic [DATA_W-1:0] headData,
  output logic              headAddrBit
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENT_W = DATA_W + 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.push) wrPtr <= nextPtr(wrPtr);
      if (stb.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  // one write port per slot, selected by the write pointer
  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (stb.push && (wrPtr == PTR_W'(i))) begin
        mem[i] <= {wrAddrBit, wrData};
      end
    end
  end

  assign {headAddrBit, headData} = mem[rdPtr];
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo
  import txq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrAddrBit,
  input  logic              fifoOn,
  input  logic              flush,
  input  logic              halfIrqEn,
  input  logic              roomIrqEn,
  input  logic              headReady,
  output logic              headValid,
  output logic [DATA_W-1:0] headData,
  output logic              headAddrBit,
  output logic              roomFlag,
  output logic              halfFlag,
  output logic              ovfFlag,
  output logic              irq
);
  txqStrobe_t stb;

  txq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .fifoOn(fifoOn), .flush(flush),
    .headReady(headReady), .halfIrqEn(halfIrqEn), .roomIrqEn(roomIrqEn),
    .stb(stb), .headValid(headValid), .roomFlag(roomFlag),
    .halfFlag(halfFlag), .ovfFlag(ovfFlag), .irq(irq)
  );

  txq_data #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .wrAddrBit(wrAddrBit), .headData(headData), .headAddrBit(headAddrBit)
  );
endmodule

// File: rtl/txq_fifo_chk.sv
module txq_fifo_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              fifoOn,
  input logic              flush,
  input logic              headReady,
  input logic              headValid,
  input logic [DATA_W-1:0] headData,
  input logic              headAddrBit,
  input logic              roomFlag,
  input logic              halfFlag,
  input logic              ovfFlag
);
  // R7
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !roomFlag && !flush) |=> ovfFlag);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !flush) |=> ovfFlag);
  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!headValid && !ovfFlag));
  // R4
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (headValid && !headReady && !flush) |=> headValid);
  // R2
  head_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (headValid && !headReady && !flush) |=> ($stable(headData) && $stable(headAddrBit)));
  // R9
  single_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoOn && headValid) |-> !roomFlag);
  // R6
  empty_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    !headValid |-> (halfFlag && roomFlag));
endmodule

bind txq_fifo txq_fifo_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .fifoOn(fifoOn), .flush(flush),
  .headReady(headReady), .headValid(headValid), .headData(headData),
  .headAddrBit(headAddrBit), .roomFlag(roomFlag), .halfFlag(halfFlag),
  .ovfFlag(ovfFlag)
);

// File: tb/tb_txq_fifo.sv
module tb_txq_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrAddrBit = 1'b0;
  logic       fifoOn = 1'b1;
  logic       flush = 1'b0;
  logic       halfIrqEn = 1'b0;
  logic       roomIrqEn = 1'b0;
  logic       headReady = 1'b0;
  logic       headValid, headAddrBit, roomFlag, halfFlag, ovfFlag, irq;
  logic [7:0] headData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [8:0] q[$];
  bit         ovfM = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txq_fifo dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrAddrBit(wrAddrBit),
    .fifoOn(fifoOn), .flush(flush), .halfIrqEn(halfIrqEn), .roomIrqEn(roomIrqEn),
    .headReady(headReady), .headValid(headValid), .headData(headData),
    .headAddrBit(headAddrBit), .roomFlag(roomFlag), .halfFlag(halfFlag),
    .ovfFlag(ovfFlag), .irq(irq)
  );

  // behavioural reference model
  always @(posedge clk) begin
    int cap;
    bit wrOk, popOk;
    cap = fifoOn ? DEPTH : 1;
    if (!rstN || flush) begin
      q.delete();
      ovfM = 0;
    end else begin
      wrOk  = wrEn && (q.size() < cap);
      popOk = headReady && (q.size() > 0);
      if (wrEn && !wrOk) ovfM = 1;
      if (popOk) void'(q.pop_front());
      if (wrOk) q.push_back({wrAddrBit, wrData});
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int cap;
    cap = fifoOn ? DEPTH : 1;
    chk("R3", "headValid", headValid, q.size() > 0);
    if (q.size() > 0) chk("R2", "head entry", {headAddrBit, headData}, q[0]);
    chk("R5", "roomFlag", roomFlag, q.size() < cap);
    chk("R6", "halfFlag", halfFlag, q.size() <= cap / 2);
    chk("R7", "ovfFlag", ovfFlag, ovfM);
    chk("R10", "irq", irq, (halfIrqEn && (q.size() <= cap / 2)) || (roomIrqEn && (q.size() < cap)));
  endtask

  // drive one cycle: compare at the negedge, then apply new inputs
  task automatic cyc(input bit w, input bit r, input bit f = 0);
    @(negedge clk);
    compare();
    wrEn      = w;
    wrData    = 8'($urandom);
    wrAddrBit = 1'($urandom);
    headReady = r;
    flush     = f;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk("R1", "headValid", headValid, 0);
    chk("R1", "roomFlag", roomFlag, 1);
    chk("R1", "halfFlag", halfFlag, 1);
    chk("R1", "ovfFlag", ovfFlag, 0);
    halfIrqEn = 1'b1;
    // R4: pop on empty
    repeat (3) cyc(0, 1);
    // R3, R6, R7: fill to 16 and beyond, crossing the 8/9 threshold
    for (int i = 0; i < 19; i++) cyc(1, 0);
    // R7: write and pop together while full: write dropped
    cyc(1, 1);
    roomIrqEn = 1'b1;
    // R2, R4: drain with gaps
    for (int i = 0; i < 24; i++) cyc(0, i % 3 != 0);
    // R11: simultaneous write and pop
    for (int i = 0; i < 10; i++) cyc(1, i > 3);
    // R8: flush with same-cycle write and pop
    cyc(1, 1, 1);
    cyc(0, 0);
    // R10: mask combinations
    halfIrqEn = 1'b0; roomIrqEn = 1'b0;
    for (int i = 0; i < 17; i++) cyc(1, 0);
    roomIrqEn = 1'b1;
    cyc(0, 0);
    halfIrqEn = 1'b1;
    cyc(0, 1, 1);
    cyc(0, 0);
    // R9: single holding register mode
    fifoOn = 1'b0;
    cyc(1, 0);
    cyc(1, 0);
    cyc(0, 1);
    cyc(1, 1);
    cyc(1, 1);
    cyc(0, 1);
    cyc(0, 0, 1);
    cyc(0, 0);
    fifoOn = 1'b1;
    // mixed traffic
    for (int i = 0; i < 300; i++) cyc(1'($urandom), 1'($urandom), ($urandom % 61) == 0);
    cyc(0, 0);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule